// File: doc/BRIEF.md
# Guaranteed-Access Bus Handoff Sequencer

This sequencer sits in a bridge between an expansion bus and a system bus. When the expansion-bus controller asks for the bus on behalf of an external master, a DMA channel or its own refresh logic, the sequencer first lets the bridge's current cycle finish. It then floats the bridge's expansion interface and acknowledges the hold. Once the controller says whether a refresh or a master is pending, the sequencer does one of two things. For a refresh it simply waits for the bus to come back. For a master it secures a memory path free of posted writes and the system bus, and only then strobes the controller so the device may be granted.

In guaranteed-access mode, memory request and flush request rise together. The memory acknowledge is a wire-OR from every bridge that flushes its buffers, and it arrives asynchronously. If the system bus is locked when its grant arrives, the sequencer withdraws its request until the lock clears. A watchdog flags a handoff that waits too long for the acknowledge or the grant.

Top module: `gat_handoff_seq`

## Requirements
- R1: A hold request sets `new_cyc_block` in the same cycle. `hold_ack` and `float_en` rise only on the clock after an edge where `hold_req` is high and `cycle_busy` is low.
- R2: `hold_ack` never rises from an edge where `self_locked` is high. The sequencer waits until it is low.
- R3: In the cycle `hold_ack` rises, `mem_req`, `flush_req` and `sys_req` are all low.
- R4: A `ctl_strobe` with `is_refresh` high keeps `hold_ack` asserted. It raises none of `mem_req`, `flush_req` or `sys_req`, whatever `mem_ack` and `sys_gnt` do. Dropping `hold_req` clears all outputs one cycle later.
- R5: With `gat_en` high, a master strobe (`is_refresh` low) raises `mem_req` and `flush_req` together on the next cycle.
- R6: `mem_ack` passes a two-flop synchronizer. `sys_req` cannot rise before the third rising edge after `mem_ack` goes high.
- R7: `sys_req` rises only once the synchronized acknowledge has been seen and `sys_lock` is low. If the lock is high at that point, the request waits and rises on the cycle after the lock goes low.
- R8: If `sys_gnt` and `sys_lock` are both high while requesting, `sys_req` drops on the next cycle and stays low while the lock is high. It rises again on the cycle after the lock goes low.
- R9: An edge with `sys_gnt` high and `sys_lock` low while requesting produces `ret_strobe` high for exactly the next cycle.
- R10: During ownership, `hold_ack`, `sys_req`, `mem_req` and `flush_req` hold (the last two only in guaranteed-access mode). When `hold_req` drops in any state, all outputs go low on the next cycle.
- R11: With `gat_en` low, a master strobe raises `sys_req` on the next cycle if the lock is low. `mem_req` and `flush_req` never rise.
- R12: `timeout` is high once TMO_CYCLES clock edges have passed in the acknowledge/grant waiting states without reaching ownership. It is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req | input | 1 | Controller asks for the expansion bus |
| cycle_busy | input | 1 | Bridge's current expansion cycle still running |
| self_locked | input | 1 | Bridge is locked as a system-bus resource |
| ctl_strobe | input | 1 | One-cycle strobe from controller after hold acknowledge |
| is_refresh | input | 1 | Qualifies `ctl_strobe`: 1 refresh, 0 master/DMA |
| mem_ack | input | 1 | Wire-OR memory acknowledge, asynchronous |
| sys_gnt | input | 1 | System-bus grant |
| sys_lock | input | 1 | System-bus lock active |
| gat_en | input | 1 | Guaranteed-access mode enable |
| hold_ack | output | 1 | Hold acknowledge to controller |
| float_en | output | 1 | Float the bridge's expansion interface |
| new_cyc_block | output | 1 | Refuse new expansion cycles |
| mem_req | output | 1 | Request for direct main-memory access |
| flush_req | output | 1 | Request to flush posted write buffers |
| sys_req | output | 1 | System-bus request |
| ret_strobe | output | 1 | One-cycle strobe: device may be granted |
| timeout | output | 1 | Acknowledge/grant wait exceeded limit |

## Verification
The hardest case to reach is a lock that is active exactly when the grant arrives, because it depends on how the grant and the lock line up in time. The same applies to a lock that is already active when the synchronized memory acknowledge lands. The bench drives both orderings by placing the lock relative to the grant edge and to the third edge after the acknowledge. Random delays, busy and self-lock windows move these points around from one handoff to the next. A directed run withholds the acknowledge to reach the watchdog limit.

// File: rtl/gat_handoff_seq.sv
module gat_handoff_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_CYCLES  = 210
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic cycle_busy,
  input  logic self_locked,
  input  logic ctl_strobe,
  input  logic is_refresh,
  input  logic mem_ack,
  input  logic sys_gnt,
  input  logic sys_lock,
  input  logic gat_en,
  output logic hold_ack,
  output logic float_en,
  output logic new_cyc_block,
  output logic mem_req,
  output logic flush_req,
  output logic sys_req,
  output logic ret_strobe,
  output logic timeout
);
  localparam int CW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_HELD, S_REFR, S_MEMW, S_ARB, S_LOCKW, S_OWN} st_t;

  st_t st, nx;
  logic [SYNC_STAGES-1:0] ack_sync;
  logic ack_s, gat_q, ret_q, waiting, owning;
  logic [CW-1:0] cnt;

  assign ack_s = ack_sync[SYNC_STAGES-1];

  always_comb begin
    nx = st;
    if (st != S_IDLE && !hold_req) nx = S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (hold_req && !cycle_busy && !self_locked) nx = S_HELD;
        S_HELD:  if (ctl_strobe) begin
                   if (is_refresh)   nx = S_REFR;
                   else if (gat_en)  nx = S_MEMW;
                   else if (sys_lock) nx = S_LOCKW;
                   else              nx = S_ARB;
                 end
        S_MEMW:  if (ack_s) nx = sys_lock ? S_LOCKW : S_ARB;
        S_ARB:   if (sys_gnt) nx = sys_lock ? S_LOCKW : S_OWN;
        S_LOCKW: if (!sys_lock) nx = S_ARB;
        default: nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ack_sync <= '0;
      gat_q    <= 1'b0;
      ret_q    <= 1'b0;
      cnt      <= '0;
    end else begin
      st       <= nx;
      ack_sync <= {ack_sync[SYNC_STAGES-2:0], mem_ack};
      ret_q    <= (st == S_ARB) && (nx == S_OWN);
      if (st == S_IDLE) gat_q <= 1'b0;
      else if (st == S_HELD && ctl_strobe) gat_q <= gat_en && !is_refresh;
      if (!waiting) cnt <= '0;
      else if (cnt != CW'(TMO_CYCLES)) cnt <= cnt + 1'b1;
    end
  end

  assign waiting       = (st == S_MEMW) || (st == S_ARB) || (st == S_LOCKW);
  assign owning        = (st == S_OWN);
  assign hold_ack      = (st != S_IDLE);
  assign float_en      = hold_ack;
  assign new_cyc_block = hold_ack || hold_req;
  assign mem_req       = gat_q && (waiting || owning);
  assign flush_req     = mem_req;
  assign sys_req       = (st == S_ARB) || owning;
  assign ret_strobe    = ret_q;
  assign timeout       = waiting && (cnt == CW'(TMO_CYCLES));
endmodule

// File: rtl/gat_handoff_chk.sv
module gat_handoff_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req,
  input logic cycle_busy,
  input logic self_locked,
  input logic ctl_strobe,
  input logic is_refresh,
  input logic sys_gnt,
  input logic sys_lock,
  input logic hold_ack,
  input logic float_en,
  input logic mem_req,
  input logic flush_req,
  input logic sys_req,
  input logic ret_strobe,
  input logic owning
);
  p_hold_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> !$past(self_locked) && !$past(cycle_busy) && $past(hold_req));

  p_clean_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> !mem_req && !flush_req && !sys_req);

  p_memflush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(ctl_strobe) && !$past(is_refresh) && flush_req);

  p_req_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_req) |-> !$past(sys_lock));

  p_backoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req && !owning && sys_gnt && sys_lock) |=> !sys_req);

  p_strobe_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |-> $past(sys_gnt) && !$past(sys_lock) && sys_req);

  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |=> !ret_strobe);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> !$past(hold_req) && !mem_req && !flush_req && !sys_req && !float_en);
endmodule

bind gat_handoff_seq gat_handoff_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cycle_busy(cycle_busy),
  .self_locked(self_locked), .ctl_strobe(ctl_strobe), .is_refresh(is_refresh),
  .sys_gnt(sys_gnt), .sys_lock(sys_lock), .hold_ack(hold_ack), .float_en(float_en),
  .mem_req(mem_req), .flush_req(flush_req), .sys_req(sys_req),
  .ret_strobe(ret_strobe), .owning(owning)
);

// File: tb/test_gat_handoff_seq.sv
module test_gat_handoff_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  localparam int PH_IDLE = 0, PH_HELD = 1, PH_MEMW = 2, PH_ARB = 3,
                 PH_LOCKW = 4, PH_OWNF = 5, PH_OWN = 6, PH_TMO = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_req = 0, cycle_busy = 0, self_locked = 0, ctl_strobe = 0, is_refresh = 0;
  logic mem_ack = 0, sys_gnt = 0, sys_lock = 0, gat_en = 0;
  logic hold_ack, float_en, new_cyc_block, mem_req, flush_req, sys_req, ret_strobe, timeout;
  logic [7:0] outv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gat_handoff_seq #(.SYNC_STAGES(2), .TMO_CYCLES(TMO)) i_gat_handoff_seq (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cycle_busy(cycle_busy),
    .self_locked(self_locked), .ctl_strobe(ctl_strobe), .is_refresh(is_refresh),
    .mem_ack(mem_ack), .sys_gnt(sys_gnt), .sys_lock(sys_lock), .gat_en(gat_en),
    .hold_ack(hold_ack), .float_en(float_en), .new_cyc_block(new_cyc_block),
    .mem_req(mem_req), .flush_req(flush_req), .sys_req(sys_req),
    .ret_strobe(ret_strobe), .timeout(timeout));

  assign outv = {hold_ack, float_en, new_cyc_block, mem_req, flush_req, sys_req, ret_strobe, timeout};

  function automatic logic [7:0] ev(int ph, bit g, bit h);
    case (ph)
      PH_IDLE:  return {2'b00, h, 5'b00000};
      PH_HELD:  return 8'b111_00000;
      PH_MEMW:  return 8'b111_11000;
      PH_ARB:   return {3'b111, g, g, 3'b100};
      PH_LOCKW: return {3'b111, g, g, 3'b000};
      PH_OWNF:  return {3'b111, g, g, 3'b110};
      PH_OWN:   return {3'b111, g, g, 3'b100};
      PH_TMO:   return 8'b111_11001;
      default:  return 8'hxx;
    endcase
  endfunction

  task automatic chk(string req, int ph, bit g, bit h);
    logic [7:0] e;
    e = ev(ph, g, h);
    checks++;
    if (outv !== e) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b (ack,flt,blk,mreq,flush,sreq,strb,tmo)",
               req, $time, outv, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic lock_window(string req, bit g, int n);
    for (int i = 0; i < n; i++) begin step(); chk(req, PH_LOCKW, g, 1); end
    sys_lock = 0; sys_gnt = 0;
    step(); chk(req, PH_ARB, g, 1);
  endtask

  task automatic handoff(bit g, bit refr, int busy, int slock, bit prelock,
                         bit grantlock, int ackdly, int gntdly, int own);
    chk("R1", PH_IDLE, g, 0);
    hold_req = 1; cycle_busy = (busy > 0);
    #1 chk("R1", PH_IDLE, g, 1);
    for (int i = 0; i < busy; i++) begin step(); chk("R1", PH_IDLE, g, 1); end
    cycle_busy = 0; self_locked = (slock > 0);
    for (int i = 0; i < slock; i++) begin step(); chk("R2", PH_IDLE, g, 1); end
    self_locked = 0;
    step(); chk("R3", PH_HELD, g, 1);
    gat_en = g; is_refresh = refr; sys_lock = prelock && !refr; ctl_strobe = 1;
    step(); ctl_strobe = 0;
    if (refr) begin
      chk("R4", PH_HELD, g, 1);
      mem_ack = 1; sys_gnt = 1;
      for (int i = 0; i < 5; i++) begin step(); chk("R4", PH_HELD, g, 1); end
      mem_ack = 0; sys_gnt = 0;
      for (int i = 0; i < 3; i++) begin step(); chk("R4", PH_HELD, g, 1); end
      hold_req = 0;
      step(); chk("R4", PH_IDLE, g, 0);
      return;
    end
    if (g) begin
      chk("R5", PH_MEMW, g, 1);
      for (int i = 0; i < ackdly; i++) begin step(); chk("R5", PH_MEMW, g, 1); end
      mem_ack = 1;
      step(); chk("R6", PH_MEMW, g, 1);
      step(); chk("R6", PH_MEMW, g, 1);
      step();
      if (prelock) begin chk("R7", PH_LOCKW, g, 1); lock_window("R7", g, 2); end
      else chk("R7", PH_ARB, g, 1);
    end else begin
      if (prelock) begin chk("R11", PH_LOCKW, g, 1); lock_window("R11", g, 2); end
      else chk("R11", PH_ARB, g, 1);
    end
    for (int i = 0; i < gntdly; i++) begin step(); chk("R7", PH_ARB, g, 1); end
    if (grantlock) begin
      sys_lock = 1; sys_gnt = 1;
      step(); chk("R8", PH_LOCKW, g, 1);
      lock_window("R8", g, 3);
    end
    sys_gnt = 1;
    step(); chk("R9", PH_OWNF, g, 1);
    for (int i = 0; i < own; i++) begin step(); chk("R10", PH_OWN, g, 1); end
    hold_req = 0; mem_ack = 0; sys_gnt = 0;
    step(); chk("R10", PH_IDLE, g, 0);
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) step();
    chk("R1", PH_IDLE, 0, 0);
    rst_n = 1;
    step(); chk("R1", PH_IDLE, 0, 0);

    handoff(1, 0, 0, 0, 0, 0, 0, 0, 2);
    handoff(1, 0, 2, 3, 1, 1, 1, 2, 3);
    handoff(0, 0, 1, 0, 0, 1, 0, 1, 2);
    handoff(0, 0, 0, 2, 1, 0, 0, 0, 1);
    handoff(1, 1, 1, 1, 0, 0, 0, 0, 0);

    for (int n = 0; n < 40; n++) begin
      handoff($urandom_range(1, 0), ($urandom_range(4, 0) == 0),
              $urandom_range(3, 0), $urandom_range(3, 0),
              $urandom_range(1, 0), $urandom_range(1, 0),
              $urandom_range(4, 0), $urandom_range(4, 0), $urandom_range(6, 0));
    end

    hold_req = 1;
    step(); chk("R3", PH_HELD, 1, 1);
    gat_en = 1; is_refresh = 0; ctl_strobe = 1;
    step(); ctl_strobe = 0; chk("R5", PH_MEMW, 1, 1);
    hold_req = 0;
    step(); chk("R10", PH_IDLE, 1, 0);

    hold_req = 1;
    step(); chk("R3", PH_HELD, 1, 1);
    ctl_strobe = 1;
    step(); ctl_strobe = 0; chk("R12", PH_MEMW, 1, 1);
    for (int j = 1; j < TMO; j++) step();
    chk("R12", PH_MEMW, 1, 1);
    step(); chk("R12", PH_TMO, 1, 1);
    step(); chk("R12", PH_TMO, 1, 1);
    hold_req = 0;
    step(); chk("R12", PH_IDLE, 1, 0);

    finish_run();
  end
endmodule